// File: doc/BRIEF.md
# Operand Cache Write Policy Controller

This block accepts CPU store requests for a four-way set-associative operand cache and applies one of two write policies, chosen by a mode input. It keeps the tag, valid and dirty state, the line data and a true-LRU rank per set. On every request it decides whether to update the cached line, to send a single word to external memory, or to allocate a line by fetching it from memory.

In write-back mode a hit is absorbed by the cache and marks the line dirty. A miss allocates a line: the controller picks a victim way, hands a dirty victim to a one-line write-back buffer, fetches the new line starting at the missed word and wrapping around, and merges the store data into that line. In write-through mode every store goes to memory as one word. A hit also updates the cached copy, and a miss leaves the cache untouched. The CPU is held (ready low) until its store has been absorbed.

Top module: `owc_write_ctrl`

## Requirements
- R1: In write-back mode (`wt_mode`=0) a hit writes the word into the cached line and sets that line dirty. It issues no external write and raises `req_ready` in the same cycle as the request.
- R2: In write-through mode (`wt_mode`=1) a hit writes the cached word and issues exactly one external write with the request address and data. It leaves the dirty bit unchanged, and `req_ready` rises in the cycle where `ext_wr_valid` and `ext_wr_ready` are both high.
- R3: Any hit, in either mode, makes the accessed way the most recently used way of its set.
- R4: In write-through mode a miss performs only one external write. It requests no fill, and it allocates no line, so a later access to the same line still misses.
- R5: A write-back miss picks as victim the lowest-numbered invalid way of the set. When all four ways are valid, it picks the least recently used way. After reset, way w holds LRU rank w, where rank 3 is the oldest.
- R6: When the victim is valid and dirty, `vb_load` pulses for one cycle before the first fill request. It carries the victim line address (offset bits zero) on `vb_addr`, and word i of the line on `vb_line[32*i +: 32]`. A clean victim produces no `vb_load`.
- R7: While `vb_busy` is high, no dirty victim is handed over and its fill does not start. The controller waits until the buffer is free.
- R8: A fill fetches the four words of the line one per `fill_req`/`fill_ack` handshake. The address bits [3:2] start at the missed word and increase by one modulo 4, for example 1, 2, 3, 0.
- R9: After a write-back fill, the line is valid and dirty, holds the fetched words with the store word merged in, and its way becomes most recently used.
- R10: After reset, all lines are invalid. With no request present, `req_ready`, `fill_req`, `ext_wr_valid` and `vb_load` are all low.
- R11: `req_ready` is never high without `req_valid`. On a write-back miss it rises only together with the fourth fill handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wt_mode | input | 1 | 1 selects write-through, 0 write-back |
| req_valid | input | 1 | CPU store request, held until ready |
| req_addr | input | 32 | Store byte address (word aligned) |
| req_data | input | 32 | Store data |
| req_ready | output | 1 | Store absorbed this cycle |
| fill_req | output | 1 | Line fill word request |
| fill_addr | output | 32 | Word address of the requested fill word |
| fill_ack | input | 1 | Fill word returned this cycle |
| fill_rdata | input | 32 | Fill word data |
| ext_wr_valid | output | 1 | Single-word external write request |
| ext_wr_addr | output | 32 | External write address |
| ext_wr_data | output | 32 | External write data |
| ext_wr_ready | input | 1 | External write accepted |
| vb_busy | input | 1 | Write-back buffer still holds a line |
| vb_load | output | 1 | Victim line handed to the buffer |
| vb_addr | output | 32 | Victim line address |
| vb_line | output | 128 | Victim line data, word i at bits 32*i |

## Verification
The bench aims at the eviction order. It fills a set with four dirty lines, touches one of them, and forces a fifth tag into that set. A design with a wrong rank update, or one that does not prefer invalid ways, evicts the wrong tag, and that shows up on `vb_addr` and `vb_line`. A directed case keeps `vb_busy` high for twenty cycles ahead of a dirty miss. A controller that ignores the buffer hands over too early or fetches before the victim has left. The bench also follows a write-through miss with a write-back store to the same line. A design that allocated on the through-write would then hit when it must fill. The wrapped fill order and the merged store word are compared against a model on every miss.

// File: rtl/owc_pkg.sv
package owc_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAY_W-1:0]            way_t;
  typedef logic [WAYS-1:0][WAY_W-1:0]  rank_vec_t;

  // rank 0 = most recent, WAYS-1 = oldest
  function automatic rank_vec_t lru_reset_order();
    rank_vec_t r;
    for (int w = 0; w < WAYS; w++) r[w] = way_t'(w);
    return r;
  endfunction

  function automatic rank_vec_t lru_touch(rank_vec_t r, way_t way);
    rank_vec_t n;
    n = r;
    for (int w = 0; w < WAYS; w++)
      if (r[w] < r[way]) n[w] = r[w] + 1'b1;
    n[way] = '0;
    return n;
  endfunction

  function automatic way_t lru_oldest(rank_vec_t r);
    way_t v;
    v = '0;
    for (int w = 0; w < WAYS; w++)
      if (r[w] == way_t'(WAYS - 1)) v = way_t'(w);
    return v;
  endfunction

  function automatic way_t lowest_free(logic [WAYS-1:0] valid);
    way_t v;
    v = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid[w]) v = way_t'(w);
    return v;
  endfunction

  function automatic int unsigned wrap_word(int unsigned start, int unsigned step,
                                            int unsigned n);
    return (start + step) % n;
  endfunction
endpackage

// File: rtl/owc_lookup.sv
module owc_lookup import owc_pkg::*; #(
  parameter int TAG_W = 26
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [WAYS-1:0]            set_dirty,
  input  rank_vec_t                  set_ranks,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output way_t                       hit_way,
  output way_t                       victim_way,
  output logic                       victim_dirty
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = set_valid[w] && (set_tags[w] == req_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = way_t'(w);
  end

  // invalid ways first, then the oldest valid way
  always_comb begin
    if (&set_valid) victim_way = lru_oldest(set_ranks);
    else            victim_way = lowest_free(set_valid);
    victim_dirty = set_valid[victim_way] && set_dirty[victim_way];
  end
endmodule

// File: rtl/owc_lru.sv
module owc_lru import owc_pkg::*; #(
  parameter int SETS = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  output rank_vec_t        rd_ranks,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  way_t             touch_way
);
  rank_vec_t ranks_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ranks_q[s] <= lru_reset_order();
    end else if (touch_en) begin
      ranks_q[touch_set] <= lru_touch(ranks_q[touch_set], touch_way);
    end
  end

  assign rd_ranks = ranks_q[rd_set];

  // R3 / R9: a touched way is the newest of its set afterwards
  assert_touch_mru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> ranks_q[$past(touch_set)][$past(touch_way)] == '0);
endmodule

// File: rtl/owc_fill_seq.sv
module owc_fill_seq import owc_pkg::*; #(
  parameter int LINE_WORDS = 4,
  localparam int WOFF_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WOFF_W-1:0] load_word,
  input  logic              adv,
  output logic [WOFF_W-1:0] word,
  output logic              last
);
  logic [WOFF_W-1:0] base_q;
  logic [WOFF_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= load_word;
      cnt_q  <= '0;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word = WOFF_W'(wrap_word(32'(base_q), 32'(cnt_q), LINE_WORDS));
  assign last = (cnt_q == WOFF_W'(LINE_WORDS - 1));

  // R8: consecutive beats step by one word, wrapping inside the line
  assert_wrap_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last && !load) |=> word == WOFF_W'(wrap_word(32'($past(word)), 1, LINE_WORDS)));
endmodule

// File: rtl/owc_write_ctrl.sv
module owc_write_ctrl import owc_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wt_mode,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_data,
  output logic                         req_ready,
  output logic                         fill_req,
  output logic [ADDR_W-1:0]            fill_addr,
  input  logic                         fill_ack,
  input  logic [DATA_W-1:0]            fill_rdata,
  output logic                         ext_wr_valid,
  output logic [ADDR_W-1:0]            ext_wr_addr,
  output logic [DATA_W-1:0]            ext_wr_data,
  input  logic                         ext_wr_ready,
  input  logic                         vb_busy,
  output logic                         vb_load,
  output logic [ADDR_W-1:0]            vb_addr,
  output logic [LINE_WORDS*DATA_W-1:0] vb_line
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;

  typedef enum logic {S_IDLE, S_FILL} state_e;

  state_e st_q;
  way_t   vway_q;

  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [DATA_W-1:0] data_q  [SETS][WAYS][LINE_WORDS];

  // request fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_set;
  logic [WOFF_W-1:0] req_word;
  logic              unused_byte_bits;
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_set  = req_addr[BOFF_W + WOFF_W +: IDX_W];
  assign req_word = req_addr[BOFF_W +: WOFF_W];
  assign unused_byte_bits = ^req_addr[BOFF_W-1:0];

  // lookup of the addressed set
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  rank_vec_t set_ranks;
  logic      hit, victim_dirty;
  way_t      hit_way, victim_way;

  always_comb
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_set][w];

  owc_lookup #(.TAG_W(TAG_W)) u_lookup (
    .set_tags     (set_tags),
    .set_valid    (valid_q[req_set]),
    .set_dirty    (dirty_q[req_set]),
    .set_ranks    (set_ranks),
    .req_tag      (req_tag),
    .hit          (hit),
    .hit_way      (hit_way),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty)
  );

  // named events
  logic ev_wb_hit, ev_wt_accept, ev_wt_hit, ev_alloc, ev_evict;
  logic ev_fill_beat, ev_fill_done;
  logic [WOFF_W-1:0] seq_word;
  logic              seq_last;

  assign ev_wb_hit    = (st_q == S_IDLE) && req_valid && !wt_mode && hit;
  assign ev_wt_accept = (st_q == S_IDLE) && req_valid && wt_mode && ext_wr_ready;
  assign ev_wt_hit    = ev_wt_accept && hit;
  assign ev_alloc     = (st_q == S_IDLE) && req_valid && !wt_mode && !hit
                        && !(victim_dirty && vb_busy);
  assign ev_evict     = ev_alloc && victim_dirty;
  assign ev_fill_beat = (st_q == S_FILL) && fill_ack;
  assign ev_fill_done = ev_fill_beat && seq_last;

  owc_fill_seq #(.LINE_WORDS(LINE_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_alloc),
    .load_word (req_word),
    .adv       (ev_fill_beat),
    .word      (seq_word),
    .last      (seq_last)
  );

  owc_lru #(.SETS(SETS)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_set    (req_set),
    .rd_ranks  (set_ranks),
    .touch_en  (ev_wb_hit || ev_wt_hit || ev_fill_done),
    .touch_set (req_set),
    .touch_way ((st_q == S_FILL) ? vway_q : hit_way)
  );

  // port drive
  assign req_ready    = ev_wb_hit || ev_wt_accept || ev_fill_done;
  assign ext_wr_valid = (st_q == S_IDLE) && req_valid && wt_mode;
  assign ext_wr_addr  = req_addr;
  assign ext_wr_data  = req_data;
  assign fill_req     = (st_q == S_FILL);
  assign fill_addr    = {req_tag, req_set, seq_word, {BOFF_W{1'b0}}};
  assign vb_load      = ev_evict;
  assign vb_addr      = {tag_q[req_set][victim_way], req_set, {(WOFF_W + BOFF_W){1'b0}}};

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_vline
    assign vb_line[i*DATA_W +: DATA_W] = data_q[req_set][victim_way][i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      vway_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0;
          for (int i = 0; i < LINE_WORDS; i++) data_q[s][w][i] <= '0;
        end
      end
    end else begin
      if (ev_wb_hit || ev_wt_hit) data_q[req_set][hit_way][req_word] <= req_data;
      if (ev_wb_hit) dirty_q[req_set][hit_way] <= 1'b1;
      if (ev_fill_beat)
        data_q[req_set][vway_q][seq_word] <= (seq_word == req_word) ? req_data : fill_rdata;
      if (ev_fill_done) begin
        tag_q[req_set][vway_q]   <= req_tag;
        valid_q[req_set][vway_q] <= 1'b1;
        dirty_q[req_set][vway_q] <= 1'b1;
      end
      case (st_q)
        S_IDLE: if (ev_alloc) begin
          st_q   <= S_FILL;
          vway_q <= victim_way;
        end
        S_FILL: if (ev_fill_done) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R1: write-back mode never drives the external write port
  assert_wb_no_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_mode |-> !ext_wr_valid);

  // R4: a fill only ever starts out of write-back mode
  assert_fill_from_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_req) |-> !$past(wt_mode));

  // R6 / R8: handover is followed by the fill, starting at the missed word
  assert_evict_then_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vb_load |=> fill_req &&
      fill_addr[BOFF_W +: WOFF_W] == $past(req_addr[BOFF_W +: WOFF_W]));

  // R7: nothing is handed to an occupied buffer
  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vb_load |-> !vb_busy);

  // R11: completion only answers a live request
  assert_ready_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);
endmodule

// File: tb/owc_write_ctrl_tb.sv
`timescale 1ns/1ps
module owc_write_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_mode = 1'b0, req_valid = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic req_ready, fill_req, ext_wr_valid, vb_load;
  logic [31:0] fill_addr, ext_wr_addr, ext_wr_data, vb_addr;
  logic fill_ack = 1'b0, ext_wr_ready = 1'b0, vb_busy = 1'b0;
  logic [31:0] fill_rdata = '0;
  logic [127:0] vb_line;

  always #2.5 clk = ~clk;

  owc_write_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack),
    .fill_rdata(fill_rdata), .ext_wr_valid(ext_wr_valid), .ext_wr_addr(ext_wr_addr),
    .ext_wr_data(ext_wr_data), .ext_wr_ready(ext_wr_ready), .vb_busy(vb_busy),
    .vb_load(vb_load), .vb_addr(vb_addr), .vb_line(vb_line)
  );

  int checks = 0, errs = 0, vb_cnt = 0;
  bit finished = 0;

  // bench model
  logic [25:0] m_tag  [4][4];
  bit          m_val  [4][4];
  bit          m_dirty[4][4];
  logic [31:0] m_data [4][4][4];
  int          m_rank [4][4];

  function automatic logic [31:0] mem_val(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int b_victim(int s);
    for (int w = 0; w < 4; w++) if (!m_val[s][w]) return w;
    for (int w = 0; w < 4; w++) if (m_rank[s][w] == 3) return w;
    return 0;
  endfunction

  task automatic b_touch(int s, int way);
    int old = m_rank[s][way];
    for (int w = 0; w < 4; w++) if (m_rank[s][w] < old) m_rank[s][w]++;
    m_rank[s][way] = 0;
  endtask

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // returns cycle of victim handover (0 if none)
  task automatic do_write(input bit wt, input logic [31:0] addr, input logic [31:0] data,
                          output int ev_cyc);
    int s = int'(addr[5:4]);
    int wd = int'(addr[3:2]);
    logic [25:0] tg = addr[31:6];
    int hw = -1, vw, beats = 0, exts = 0, cyc = 0;
    bit exp_ev, seen_ev = 0, done = 0;
    logic [31:0] exp_vaddr, exp_fa;
    logic [127:0] exp_line;
    ev_cyc = 0;
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == tg) hw = w;
    vw = b_victim(s);
    exp_ev = !wt && hw < 0 && m_val[s][vw] && m_dirty[s][vw];
    exp_vaddr = {m_tag[s][vw], 2'(s), 4'h0};
    for (int i = 0; i < 4; i++) exp_line[i*32 +: 32] = m_data[s][vw][i];
    @(negedge clk);
    wt_mode = wt; req_valid = 1'b1; req_addr = addr; req_data = data;
    while (!done && cyc < 400) begin
      if (cyc > 0) @(negedge clk);
      ext_wr_ready = ($urandom % 3) != 0;
      fill_ack = ($urandom % 4) != 0;
      fill_rdata = mem_val(fill_addr);
      vb_busy = vb_cnt > 0;
      if (vb_cnt > 0) vb_cnt--;
      #1;
      fill_rdata = mem_val(fill_addr);
      #0.1;
      cyc++;
      if (vb_load) begin
        chk(exp_ev && !seen_ev, "R6", "unexpected victim load", 128'(vb_load), 128'(exp_ev));
        chk(!vb_busy, "R7", "load while busy", 128'(vb_busy), 128'(0));
        chk(beats == 0 && !fill_req, "R6", "load after fill began", 128'(beats), 128'(0));
        chk(vb_addr == exp_vaddr, "R6", "victim address", 128'(vb_addr), 128'(exp_vaddr));
        chk(vb_line == exp_line, "R6", "victim data", vb_line, exp_line);
        seen_ev = 1; ev_cyc = cyc;
        vb_cnt = int'($urandom % 9);
      end
      if (fill_req && fill_ack) begin
        exp_fa = {tg, 2'(s), 2'((wd + beats) % 4), 2'b00};
        chk(fill_addr == exp_fa, "R8", "fill order", 128'(fill_addr), 128'(exp_fa));
        if (exp_ev) chk(seen_ev, "R6", "fill before handover", 128'(seen_ev), 128'(1));
        beats++;
      end
      if (ext_wr_valid && ext_wr_ready) begin
        chk(ext_wr_addr == addr && ext_wr_data == data, wt ? (hw >= 0 ? "R2" : "R4") : "R1",
            "external write", {ext_wr_addr, ext_wr_data}, {addr, data});
        exts++;
      end
      if (req_ready) begin
        done = 1;
        if (!wt && hw < 0)
          chk(beats == 4, "R11", "ready before fill end", 128'(beats), 128'(4));
        if (!wt && hw >= 0)
          chk(cyc == 1, "R1", "hit latency", 128'(cyc), 128'(1));
      end
    end
    chk(done, "R11", "request never completed", 128'(done), 128'(1));
    chk(exts == (wt ? 1 : 0), wt ? "R2" : "R1", "external write count", 128'(exts), 128'(wt ? 1 : 0));
    chk(beats == ((!wt && hw < 0) ? 4 : 0), wt ? "R4" : "R9", "fill beat count",
        128'(beats), 128'((!wt && hw < 0) ? 4 : 0));
    chk(seen_ev == exp_ev, "R5", "victim choice / dirty handover", 128'(seen_ev), 128'(exp_ev));
    // model update
    if (hw >= 0) begin
      m_data[s][hw][wd] = data;
      if (!wt) m_dirty[s][hw] = 1;
      b_touch(s, hw);
    end else if (!wt) begin
      for (int i = 0; i < 4; i++)
        m_data[s][vw][i] = (i == wd) ? data : mem_val({tg, 2'(s), 2'(i), 2'b00});
      m_tag[s][vw] = tg; m_val[s][vw] = 1; m_dirty[s][vw] = 1;
      b_touch(s, vw);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(int tg, int s, int w);
    return {26'(tg), 2'(s), 2'(w), 2'b00};
  endfunction

  initial begin
    #(5.0 * 200000);
    checks++; errs++;
    $display("FAIL watchdog expired act=1 exp=0");
    summary();
  end

  initial begin
    int evc;
    void'($urandom(32'd2024));
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 0; m_dirty[s][w] = 0; m_rank[s][w] = w; m_tag[s][w] = '0;
        for (int i = 0; i < 4; i++) m_data[s][w][i] = '0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(!req_ready && !fill_req && !ext_wr_valid && !vb_load, "R10", "idle outputs",
        {req_ready, fill_req, ext_wr_valid, vb_load}, 128'(0));

    // write-back miss into empty set, word 1 (R8 wrap 1,2,3,0)
    do_write(0, mk(10, 0, 1), 32'h1111_0001, evc);
    do_write(0, mk(10, 0, 3), 32'h1111_0003, evc);          // R1 hit
    do_write(1, mk(10, 0, 2), 32'h2222_0002, evc);          // R2 through-write hit
    do_write(1, mk(20, 0, 0), 32'h3333_0000, evc);          // R4 through-write miss
    do_write(0, mk(20, 0, 2), 32'h3333_0002, evc);          // R4 still misses -> fill
    // R5/R3: fill set 1, touch way of tag 31, then evict oldest
    for (int t = 30; t < 34; t++) do_write(0, mk(t, 1, t % 4), 32'hA000_0000 + t, evc);
    do_write(0, mk(31, 1, 0), 32'hB000_0031, evc);          // R3 hit touch
    do_write(1, mk(30, 1, 1), 32'hB000_0030, evc);          // R3 touch via through-write
    do_write(0, mk(34, 1, 2), 32'hC000_0034, evc);          // evicts oldest dirty line
    // R7: buffer held busy before a dirty miss
    vb_cnt = 20;
    do_write(0, mk(35, 1, 3), 32'hD000_0035, evc);
    chk(evc >= 21, "R7", "handover while buffer busy", 128'(evc), 128'(21));
    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      bit wt = ($urandom % 4) == 0;
      logic [31:0] a = mk(100 + int'($urandom % 6), int'($urandom % 4), int'($urandom % 4));
      do_write(wt, a, $urandom, evc);
    end
    @(negedge clk); #1;
    chk(!req_ready && !fill_req && !ext_wr_valid, "R11", "quiet without request",
        {req_ready, fill_req, ext_wr_valid}, 128'(0));
    summary();
  end
endmodule